// File: doc/BRIEF.md
# Funnel Shift and Bit-Field Extract Unit

This is a combinational datapath unit for the shift-and-field slot of a 32-bit integer pipeline whose bit positions are numbered from the most significant end. It performs one of two operations. The first is a funnel shift: two operand words are joined into a double-width value, which is shifted right, and the lower word of the shifted value is returned. The second pulls a bit field out of one operand and widens it to the full word, either with zeros or with copies of the field's top bit.

Positions arrive in the instruction's own numbering, where bit 0 is the most significant bit. The unit mirrors them (word width minus one, minus the value) before it uses them. A field length arrives as the word width minus the length, so an encoded 0 means a field as wide as the word. The shift-amount register value comes in as a plain input. After each operation, a 3-bit condition selector is tested against the result, and the outcome drives a flag that asks the pipeline to squash the next instruction. The register file, operand bypass and the rest of the condition table are handled elsewhere.

Top module: `shx_unit`

## Requirements
- R1: With op_sel 0 (funnel, register amount) or 1 (funnel, immediate amount), result is the low W bits of the 2W-bit value {opnd_x, opnd_y} shifted right by the amount; opnd_x is the high word.
- R2: The funnel amount is sar when op_sel is 0, and W-1-imm_pos when op_sel is 1.
- R3: When opnd_x equals opnd_y, a funnel operation yields opnd_y rotated right by the amount.
- R4: When opnd_x is zero, a funnel operation yields opnd_y shifted right logically by the amount.
- R5: A funnel operation with an amount of zero returns opnd_y unchanged.
- R6: With op_sel 2 (extract, register position) or 3 (extract, immediate position), the field length is W minus imm_clen (1 to W). With sign_ext 0, every result bit at or above the length is zero.
- R7: The field's least significant bit is source bit W-1-imm_pos for op_sel 3, and W-1-sar for op_sel 2. The source is opnd_y, and bits above the top of the source are read as zero.
- R8: With sign_ext 1, every result bit at or above the length copies the field's top bit. When the field reaches past the source's top bit, that bit reads as opnd_y[W-1], because the shift is arithmetic.
- R9: cond 0 never raises nullify_nxt.
- R10: cond 1 raises nullify_nxt exactly when result is zero.
- R11: cond 2 raises nullify_nxt exactly when result bit W-1 is set.
- R12: cond values 3 through 7 never raise nullify_nxt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_x | input | W | Funnel high word |
| opnd_y | input | W | Funnel low word; extract source |
| sar | input | log2(W) | Shift-amount register value |
| imm_pos | input | log2(W) | Immediate position, numbered from the MSB |
| imm_clen | input | log2(W) | Encoded length, W minus the field length |
| op_sel | input | 2 | 0/1 funnel reg/imm, 2/3 extract reg/imm |
| sign_ext | input | 1 | Extract widens with the field's top bit |
| cond | input | 3 | Condition selector for nullify_nxt |
| result | output | W | Operation result |
| nullify_nxt | output | 1 | Request to squash the next instruction |

## Verification
The bench builds the unit with the default W of 32, which keeps the 5-bit fields. At that size every funnel amount in both forms, and every pairing of position and encoded length for extraction, can be swept in full, with and without sign extension. The sweep reaches the wrap cases: full-word fields, fields that run past the source's top bit, and zero shifts. These are compared against a model built from 64-bit shifts and masks.

// File: rtl/shx_pkg.sv
// Shared encodings for the shift/extract unit.
// Assumes op_sel and cond are decoded from the instruction upstream.
package shx_pkg;
    typedef enum logic [1:0] {
        OP_FUN_REG = 2'd0,
        OP_FUN_IMM = 2'd1,
        OP_EXT_REG = 2'd2,
        OP_EXT_IMM = 2'd3
    } shx_op_e;

    typedef enum logic [2:0] {
        CND_NEVER = 3'd0,
        CND_ZERO  = 3'd1,
        CND_NEG   = 3'd2
    } shx_cond_e;
endpackage

// File: rtl/shx_funnel.sv
// Funnel shifter: joins hi:lo and returns the low word after a right shift.
// Assumes W is a power of two and amt < W.
module shx_funnel #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   hi,
    input  logic [W-1:0]   lo,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   dout
);
    logic [2*W-1:0] pair_sh;

    // Shift the concatenated pair and keep the lower word.
    always_comb begin
        pair_sh = {hi, lo} >> amt;
        dout    = pair_sh[W-1:0];
    end
endmodule

// File: rtl/shx_extract.sv
// Bit-field extractor: the field's LSB sits at W-1-pos, and its length is W-clen.
// Assumes pos and clen are already selected (register or immediate form).
module shx_extract #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   src,
    input  logic [SHW-1:0] pos,
    input  logic [SHW-1:0] clen,
    input  logic           sext,
    output logic [W-1:0]   dout
);
    localparam logic [SHW-1:0] MAXP = SHW'(W - 1);

    logic [SHW-1:0] shamt;
    logic [SHW-1:0] top_idx;
    logic [W-1:0]   shifted;
    logic [W-1:0]   mask;
    logic           top_bit;

    // Align the field to bit 0; use an arithmetic shift when sign-extending.
    always_comb begin
        shamt   = MAXP - pos;
        shifted = sext ? W'($signed(src) >>> shamt) : (src >> shamt);
    end

    // Mask to the field length and widen with zeros or the field's top bit.
    always_comb begin
        mask    = {W{1'b1}} >> clen;
        top_idx = MAXP - clen;
        top_bit = shifted[top_idx];
        dout    = (shifted & mask) | ((sext && top_bit) ? ~mask : '0);
    end
endmodule

// File: rtl/shx_cond.sv
// Nullify-condition evaluator on the unit's result.
// Assumes unsupported selector values mean "never".
module shx_cond #(
    parameter int W = 32
) (
    input  logic [W-1:0] res,
    input  logic [2:0]   sel,
    output logic         hit
);
    import shx_pkg::*;

    // Decode the selector against the result.
    always_comb begin
        case (sel)
            CND_ZERO: hit = (res == '0);
            CND_NEG:  hit = res[W-1];
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/shx_unit.sv
// Top of the shift/extract unit: picks the amount source, runs the funnel
// or the extractor, and evaluates the nullify condition on the result.
// Purely combinational; positions are numbered from the MSB.
module shx_unit #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   opnd_x,
    input  logic [W-1:0]   opnd_y,
    input  logic [SHW-1:0] sar,
    input  logic [SHW-1:0] imm_pos,
    input  logic [SHW-1:0] imm_clen,
    input  logic [1:0]     op_sel,
    input  logic           sign_ext,
    input  logic [2:0]     cond,
    output logic [W-1:0]   result,
    output logic           nullify_nxt
);
    import shx_pkg::*;

    localparam logic [SHW-1:0] MAXP = SHW'(W - 1);

    logic [SHW-1:0] fun_amt;
    logic [SHW-1:0] ext_pos;
    logic [W-1:0]   fun_out;
    logic [W-1:0]   ext_out;

    // Select the funnel amount and the extract position from register or immediate.
    always_comb begin
        fun_amt = (op_sel == OP_FUN_REG) ? sar : (MAXP - imm_pos);
        ext_pos = (op_sel == OP_EXT_REG) ? sar : imm_pos;
    end

    shx_funnel #(.W(W), .SHW(SHW)) u_fun (
        .hi   (opnd_x),
        .lo   (opnd_y),
        .amt  (fun_amt),
        .dout (fun_out)
    );

    shx_extract #(.W(W), .SHW(SHW)) u_ext (
        .src  (opnd_y),
        .pos  (ext_pos),
        .clen (imm_clen),
        .sext (sign_ext),
        .dout (ext_out)
    );

    // Route the active operation to the result.
    always_comb begin
        result = op_sel[1] ? ext_out : fun_out;
    end

    shx_cond #(.W(W)) u_cnd (
        .res (result),
        .sel (cond),
        .hit (nullify_nxt)
    );
endmodule

// File: rtl/shx_unit_chk.sv
// Checker for shx_unit: immediate assertions relating ports, bound to the top.
// Assumes the unit is combinational, so each check is evaluated as its inputs settle.
module shx_unit_chk #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input logic [W-1:0]   opnd_x,
    input logic [W-1:0]   opnd_y,
    input logic [SHW-1:0] sar,
    input logic [SHW-1:0] imm_pos,
    input logic [SHW-1:0] imm_clen,
    input logic [1:0]     op_sel,
    input logic           sign_ext,
    input logic [2:0]     cond,
    input logic [W-1:0]   result,
    input logic           nullify_nxt
);
    logic [SHW-1:0] c_amt;
    logic [SHW:0]   c_len;
    logic [SHW:0]   c_rev;
    logic [W-1:0]   c_hi;
    logic           c_fun;

    // Derive the reference amount and length from the ports.
    always_comb begin
        c_fun = !op_sel[1];
        c_amt = (op_sel == 2'd0) ? sar : SHW'((W - 1) - int'(imm_pos));
        c_len = (SHW + 1)'(W - int'(imm_clen));
        c_rev = (SHW + 1)'(W - int'(c_amt));
        c_hi  = result >> (c_len - 1'b1);
    end

    // Check each port relation.
    always_comb begin
        assert_cond_never_R9: assert (!(cond == 3'd0 && nullify_nxt));
        assert_cond_zero_R10: assert (cond != 3'd1 || nullify_nxt == (result == '0));
        assert_cond_neg_R11: assert (cond != 3'd2 || nullify_nxt == result[W-1]);
        assert_cond_rsvd_R12: assert (cond < 3'd3 || !nullify_nxt);
        assert_zero_amt_R5: assert (!(c_fun && c_amt == '0) || result == opnd_y);
        assert_hi_zero_R4: assert (!(c_fun && opnd_x == '0) || result == (opnd_y >> c_amt));
        assert_rotate_R3: assert (!(c_fun && opnd_x == opnd_y) ||
                                  result == ((opnd_y >> c_amt) | (opnd_y << c_rev)));
        assert_zext_R6: assert (!(!c_fun && !sign_ext) || (result >> c_len) == '0);
        assert_sext_R8: assert (!(!c_fun && sign_ext) ||
                                c_hi == '0 || c_hi == ({W{1'b1}} >> (c_len - 1'b1)));
    end
endmodule

bind shx_unit shx_unit_chk #(.W(W), .SHW(SHW)) u_chk (
    .opnd_x      (opnd_x),
    .opnd_y      (opnd_y),
    .sar         (sar),
    .imm_pos     (imm_pos),
    .imm_clen    (imm_clen),
    .op_sel      (op_sel),
    .sign_ext    (sign_ext),
    .cond        (cond),
    .result      (result),
    .nullify_nxt (nullify_nxt)
);

// File: tb/sim_shx_unit.sv
module sim_shx_unit;
    localparam int W      = 32;
    localparam int SHW    = 5;
    localparam int CLK_NS = 10;
    localparam int WD_MAX = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0]   opnd_x = '0, opnd_y = '0;
    logic [SHW-1:0] sar = '0, imm_pos = '0, imm_clen = '0;
    logic [1:0]     op_sel = '0;
    logic           sign_ext = 1'b0;
    logic [2:0]     cond = '0;
    logic [W-1:0]   result;
    logic           nullify_nxt;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    shx_unit #(.W(W)) u0 (
        .opnd_x(opnd_x), .opnd_y(opnd_y), .sar(sar), .imm_pos(imm_pos),
        .imm_clen(imm_clen), .op_sel(op_sel), .sign_ext(sign_ext), .cond(cond),
        .result(result), .nullify_nxt(nullify_nxt)
    );

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Independent model from 64-bit shifts and masks.
    function automatic logic [W-1:0] model(logic [1:0] op, logic [31:0] x, logic [31:0] y,
                                           int s, int p, int cl, bit se);
        longint unsigned pr, fld, m;
        int amt, len, lsb;
        if (op < 2) begin
            amt = (op == 0) ? s : 31 - p;
            pr  = ({32'h0, x} << 32) | {32'h0, y};
            return 32'(pr >> amt);
        end
        len = 32 - cl;
        lsb = 31 - ((op == 2) ? s : p);
        pr  = se ? longint'(signed'(y)) : {32'h0, y};
        fld = pr >> lsb;
        m   = (64'd1 << len) - 1;
        fld = fld & m;
        if (se && fld[len-1]) fld = fld | ~m;
        return 32'(fld);
    endfunction

    task automatic apply(logic [1:0] op, logic [31:0] x, logic [31:0] y,
                         int s, int p, int cl, bit se, logic [2:0] c);
        @(negedge clk);
        op_sel = op; opnd_x = x; opnd_y = y; sar = SHW'(s); imm_pos = SHW'(p);
        imm_clen = SHW'(cl); sign_ext = se; cond = c;
        #1;
    endtask

    task automatic t_idle;
        apply(2'd0, '0, '0, 0, 0, 0, 1'b0, 3'd0);
        check("R1 idle result", result, '0);
        check("R9 idle nullify", W'(nullify_nxt), '0);
    endtask

    task automatic t_funnel;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] x = $urandom, y = $urandom;
            for (int a = 0; a < 32; a++) begin
                apply(2'd0, x, y, a, 0, 0, 1'b0, 3'd0);
                check("R1/R2 funnel reg", result, model(2'd0, x, y, a, 0, 0, 1'b0));
                apply(2'd1, x, y, 0, a, 0, 1'b0, 3'd0);
                check("R1/R2 funnel imm", result, model(2'd1, x, y, 0, a, 0, 1'b0));
            end
        end
    endtask

    task automatic t_rotate;
        logic [31:0] y = 32'h8123_4567;
        for (int a = 0; a < 32; a++) begin
            apply(2'd0, y, y, a, 0, 0, 1'b0, 3'd0);
            check("R3 rotate", result, (y >> a) | 32'(64'(y) << (32 - a)));
        end
    endtask

    task automatic t_hi_zero;
        logic [31:0] y = 32'hF0F0_1234;
        for (int a = 0; a < 32; a++) begin
            apply(2'd1, '0, y, 0, 31 - a, 0, 1'b0, 3'd0);
            check("R4 logical shift", result, y >> a);
        end
    endtask

    task automatic t_zero_amt;
        apply(2'd0, 32'hDEAD_BEEF, 32'h1357_9BDF, 0, 0, 0, 1'b0, 3'd0);
        check("R5 sar zero", result, 32'h1357_9BDF);
        apply(2'd1, 32'hDEAD_BEEF, 32'h2468_ACE0, 0, 31, 0, 1'b0, 3'd0);
        check("R5 imm zero", result, 32'h2468_ACE0);
    endtask

    task automatic t_extract;
        for (int f = 2; f < 4; f++) begin
            for (int se = 0; se < 2; se++) begin
                logic [31:0] y = (se != 0) ? 32'h9A5C_3E71 : $urandom;
                for (int p = 0; p < 32; p++)
                    for (int cl = 0; cl < 32; cl++) begin
                        apply(2'(f), 32'h5555_AAAA, y, p, p, cl, 1'(se), 3'd0);
                        check(se != 0 ? "R7/R8 sext field" : "R6/R7 zext field",
                              result, model(2'(f), 32'h5555_AAAA, y, p, p, cl, 1'(se)));
                    end
            end
        end
        apply(2'd3, '0, 32'hFFFF_FFFF, 0, 31, 31, 1'b0, 3'd0);
        check("R6 one bit zext", result, 32'h1);
        apply(2'd3, '0, 32'h8000_0000, 0, 0, 0, 1'b1, 3'd0);
        check("R8 past top sext", result, 32'hFFFF_FFFF);
        apply(2'd2, '0, 32'h8000_0000, 0, 0, 0, 1'b0, 3'd0);
        check("R7 past top zext", result, 32'h1);
    endtask

    task automatic t_cond;
        apply(2'd0, '0, '0, 0, 0, 0, 1'b0, 3'd1);
        check("R10 zero hit", W'(nullify_nxt), 1);
        apply(2'd0, '0, 32'h1, 0, 0, 0, 1'b0, 3'd1);
        check("R10 nonzero miss", W'(nullify_nxt), 0);
        apply(2'd0, '0, 32'h8000_0000, 0, 0, 0, 1'b0, 3'd2);
        check("R11 negative hit", W'(nullify_nxt), 1);
        apply(2'd0, '0, 32'h7FFF_FFFF, 0, 0, 0, 1'b0, 3'd2);
        check("R11 positive miss", W'(nullify_nxt), 0);
        apply(2'd0, '0, 32'h8000_0000, 0, 0, 0, 1'b0, 3'd0);
        check("R9 never on negative", W'(nullify_nxt), 0);
        apply(2'd0, '0, '0, 0, 0, 0, 1'b0, 3'd0);
        check("R9 never on zero", W'(nullify_nxt), 0);
        for (int c = 3; c < 8; c++) begin
            apply(2'd0, '0, '0, 0, 0, 0, 1'b0, 3'(c));
            check("R12 reserved on zero", W'(nullify_nxt), 0);
            apply(2'd0, '0, 32'h8000_0000, 0, 0, 0, 1'b0, 3'(c));
            check("R12 reserved on negative", W'(nullify_nxt), 0);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_idle;
        t_funnel;
        t_rotate;
        t_hi_zero;
        t_zero_amt;
        t_extract;
        t_cond;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < WD_MAX; i++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=done", WD_MAX);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule